// File: doc/BRIEF.md
# I2C Start and Stop Condition Sequencer

This block generates the bus conditions that open and close an I2C transfer: a START from an idle bus, a repeated START from the middle of a transfer (SCL low), and a STOP. It drives two open-drain pull-down enables, one for SCL and one for SDA. A value of 1 pulls the line low and a value of 0 releases it. When the condition is complete it raises `done` for one clock. After a START or repeated START it leaves both lines pulled low, ready for the first data bit. After a STOP it leaves both lines released.

All intervals are built from a high time base of one unit = 8*h clocks, where h = `div_high` + 1. The START setup interval runs from SCL high to SDA falling and lasts 8*h*u + 1 clocks. The START hold interval runs from SDA falling to SCL falling and lasts 8*h*(u+1) - 1 clocks. The STOP setup interval runs from SCL high to SDA rising and lasts 8*h*p + 1 clocks. Here u and p are two-bit setup counts plus one. The intervals are whole multiples of the unit, so the start setup time is never cut short to a fraction of one high time. The divider and counts are captured when a command is accepted. A command is accepted only while the sequencer is idle.

Operation is a state machine with eight states. IDLE holds the lines as the last condition left them. RS_PREP releases SDA with SCL still low. ST_SETUP releases both lines. ST_HOLD pulls SDA low with SCL released. ST_DONE pulls both lines low and pulses `done`. SP_PREP pulls both lines low. SP_SETUP releases SCL with SDA still low. SP_DONE releases both lines and pulses `done`.

The transitions are as follows:
- IDLE goes to ST_SETUP on a start command, to RS_PREP on a repeated start, and to SP_PREP on a stop.
- RS_PREP goes to ST_SETUP when its interval expires, and ST_SETUP goes to ST_HOLD the same way.
- ST_HOLD goes to ST_DONE when its interval expires.
- SP_PREP goes to SP_SETUP when its interval expires, and SP_SETUP goes to SP_DONE the same way.
- ST_DONE and SP_DONE return to IDLE after one clock.

Top module: `i2c_cond_seq`

## Requirements
- R1: Out of reset both enables are 0 (lines released) and `done` is 0, and they stay so until a command is accepted.
- R2: A start (op 01) accepted at a clock edge releases both lines for 8*h*u + 1 clocks and then pulls SDA low. Here h = `div_high` + 1 and u = `setup_ctl[1:0]` + 1.
- R3: After SDA falls in a start or repeated start, SCL stays released for 8*h*(u+1) - 1 clocks and is then pulled low. Both lines then remain pulled low while the sequencer is idle.
- R4: A repeated start (op 10) first releases SDA with SCL pulled low for 8*h clocks. It then releases SCL and continues exactly as R2 and R3 from the setup interval on.
- R5: A stop (op 11) pulls both lines low for 8*h clocks. It then releases SCL with SDA held low for 8*h*p + 1 clocks, where p = `setup_ctl[3:2]` + 1. It then releases SDA and leaves both lines released.
- R6: `done` is high for exactly one clock. That clock is the first clock of the final line state of each condition: SCL falling for a start, SDA rising for a stop.
- R7: A command that arrives while the sequencer is busy is ignored, including in the `done` cycle. A command with op 00 is ignored.
- R8: `div_high` and `setup_ctl` are sampled only at the edge that accepts a command. Changes while busy have no effect on the condition in progress.
- R9: The op codes are 01 = start, 10 = repeated start, 11 = stop. `setup_ctl[1:0]` holds the start setup count and `setup_ctl[3:2]` holds the stop setup count. These are the top four bits of a 16-bit control word, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | Condition to generate (R9 encoding) |
| div_high | input | 16 | High divider; h = div_high + 1 |
| setup_ctl | input | 4 | [1:0] start setup count, [3:2] stop setup count |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | One-clock pulse at condition completion |

## Verification
The two functions that can fall in the same cycle are the completion pulse of one condition and the arrival of the next command. At that moment the sequencer is still in its final state, so the command must be dropped. This is provoked by holding `cmd_valid` high with a stop op for the whole length of a start. The expected result is that the stop is ignored through the `done` clock and accepted on the following edge. A second overlap pairs a divider and count change, together with a competing command, with the running intervals. The reference model keeps the interval lengths it computed at acceptance, and the lines are compared against it on every clock.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_START  = 2'b01,
        OP_RSTART = 2'b10,
        OP_STOP   = 2'b11
    } cond_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RS_PREP,
        S_ST_SETUP,
        S_ST_HOLD,
        S_ST_DONE,
        S_SP_PREP,
        S_SP_SETUP,
        S_SP_DONE
    } seq_state_e;

endpackage

// File: rtl/i2c_cond_cfg.sv
module i2c_cond_cfg #(
    parameter int DIV_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             use_live,
    input  logic [DIV_W-1:0] divh_in,
    input  logic [SEL_W-1:0] sta_in,
    input  logic [SEL_W-1:0] sto_in,
    output logic [DIV_W-1:0] divh_q,
    output logic [DIV_W-1:0] divh_eff,
    output logic [SEL_W-1:0] sta_eff,
    output logic [SEL_W-1:0] sto_eff
);
    logic [SEL_W-1:0] sta_q;
    logic [SEL_W-1:0] sto_q;

    // Configuration is frozen at acceptance (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            divh_q <= '0;
            sta_q  <= '0;
            sto_q  <= '0;
        end else if (capture) begin
            divh_q <= divh_in;
            sta_q  <= sta_in;
            sto_q  <= sto_in;
        end
    end

    // The first interval is loaded in the accepting cycle, from live inputs
    always_comb begin
        divh_eff = use_live ? divh_in : divh_q;
        sta_eff  = use_live ? sta_in  : sta_q;
        sto_eff  = use_live ? sto_in  : sto_q;
    end
endmodule

// File: rtl/i2c_cond_timing.sv
module i2c_cond_timing #(
    parameter int DIV_W = 16,
    parameter int SEL_W = 2,
    parameter int CNT_W = DIV_W + SEL_W + 5
) (
    input  logic [DIV_W-1:0] divh,
    input  logic [SEL_W-1:0] sta_sel,
    input  logic [SEL_W-1:0] sto_sel,
    output logic [CNT_W-1:0] prep_m1,
    output logic [CNT_W-1:0] sta_setup_m1,
    output logic [CNT_W-1:0] sta_hold_m1,
    output logic [CNT_W-1:0] sto_setup_m1
);
    localparam int SUBPHASES_LOG2 = 3;

    logic [CNT_W-1:0] h_w;
    logic [CNT_W-1:0] unit_w;
    logic [CNT_W-1:0] u_w;
    logic [CNT_W-1:0] p_w;

    // Reload values are interval length minus one
    always_comb begin
        h_w          = CNT_W'(divh) + CNT_W'(1);
        unit_w       = h_w << SUBPHASES_LOG2;
        u_w          = CNT_W'(sta_sel) + CNT_W'(1);
        p_w          = CNT_W'(sto_sel) + CNT_W'(1);
        prep_m1      = unit_w - CNT_W'(1);
        sta_setup_m1 = unit_w * u_w;
        sta_hold_m1  = unit_w * (u_w + CNT_W'(1)) - CNT_W'(2);
        sto_setup_m1 = unit_w * p_w;
    end
endmodule

// File: rtl/i2c_cond_timer.sv
module i2c_cond_timer #(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2c_cond_fsm.sv
module i2c_cond_fsm
    import i2c_cond_pkg::*;
#(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             expired,
    input  logic [CNT_W-1:0] prep_m1,
    input  logic [CNT_W-1:0] sta_setup_m1,
    input  logic [CNT_W-1:0] sta_hold_m1,
    input  logic [CNT_W-1:0] sto_setup_m1,
    output seq_state_e       state_q,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             done
);
    seq_state_e state_d;
    logic       park_scl_q;
    logic       park_sda_q;
    cond_op_e   op_w;

    assign op_w   = cond_op_e'(cmd_op);
    assign accept = (state_q == S_IDLE) && cmd_valid && (op_w != OP_NONE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Line levels left behind while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            park_scl_q <= 1'b0;
            park_sda_q <= 1'b0;
        end else if (state_q == S_ST_DONE) begin
            park_scl_q <= 1'b1;
            park_sda_q <= 1'b1;
        end else if (state_q == S_SP_DONE) begin
            park_scl_q <= 1'b0;
            park_sda_q <= 1'b0;
        end
    end

    // Transitions and interval loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    unique case (op_w)
                        OP_START: begin
                            state_d = S_ST_SETUP;
                            tmr_val = sta_setup_m1;
                        end
                        OP_RSTART: begin
                            state_d = S_RS_PREP;
                            tmr_val = prep_m1;
                        end
                        default: begin
                            state_d = S_SP_PREP;
                            tmr_val = prep_m1;
                        end
                    endcase
                end
            end
            S_RS_PREP: begin
                if (expired) begin
                    state_d  = S_ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = sta_setup_m1;
                end
            end
            S_ST_SETUP: begin
                if (expired) begin
                    state_d  = S_ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = sta_hold_m1;
                end
            end
            S_ST_HOLD: begin
                if (expired) begin
                    state_d = S_ST_DONE;
                end
            end
            S_SP_PREP: begin
                if (expired) begin
                    state_d  = S_SP_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = sto_setup_m1;
                end
            end
            S_SP_SETUP: begin
                if (expired) begin
                    state_d = S_SP_DONE;
                end
            end
            S_ST_DONE,
            S_SP_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                scl_oe = park_scl_q;
                sda_oe = park_sda_q;
            end
            S_RS_PREP: begin
                scl_oe = 1'b1;
                sda_oe = 1'b0;
            end
            S_ST_SETUP: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            S_ST_HOLD: begin
                scl_oe = 1'b0;
                sda_oe = 1'b1;
            end
            S_ST_DONE: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
                done   = 1'b1;
            end
            S_SP_PREP: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            S_SP_SETUP: begin
                scl_oe = 1'b0;
                sda_oe = 1'b1;
            end
            S_SP_DONE: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
                done   = 1'b1;
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int SEL_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [DIV_W-1:0]   div_high,
    input  logic [2*SEL_W-1:0] setup_ctl,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               done
);
    localparam int CNT_W = DIV_W + SEL_W + 5;

    seq_state_e       state_w;
    logic             accept_w;
    logic             tmr_load_w;
    logic [CNT_W-1:0] tmr_val_w;
    logic             expired_w;
    logic [DIV_W-1:0] divh_lat_w;
    logic [DIV_W-1:0] divh_eff_w;
    logic [SEL_W-1:0] sta_eff_w;
    logic [SEL_W-1:0] sto_eff_w;
    logic [CNT_W-1:0] prep_m1_w;
    logic [CNT_W-1:0] sta_setup_m1_w;
    logic [CNT_W-1:0] sta_hold_m1_w;
    logic [CNT_W-1:0] sto_setup_m1_w;

    i2c_cond_cfg #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept_w),
        .use_live (state_w == S_IDLE),
        .divh_in  (div_high),
        .sta_in   (setup_ctl[SEL_W-1:0]),
        .sto_in   (setup_ctl[2*SEL_W-1:SEL_W]),
        .divh_q   (divh_lat_w),
        .divh_eff (divh_eff_w),
        .sta_eff  (sta_eff_w),
        .sto_eff  (sto_eff_w)
    );

    i2c_cond_timing #(.DIV_W(DIV_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_timing (
        .divh         (divh_eff_w),
        .sta_sel      (sta_eff_w),
        .sto_sel      (sto_eff_w),
        .prep_m1      (prep_m1_w),
        .sta_setup_m1 (sta_setup_m1_w),
        .sta_hold_m1  (sta_hold_m1_w),
        .sto_setup_m1 (sto_setup_m1_w)
    );

    i2c_cond_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load_w),
        .load_val (tmr_val_w),
        .expired  (expired_w)
    );

    i2c_cond_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .expired      (expired_w),
        .prep_m1      (prep_m1_w),
        .sta_setup_m1 (sta_setup_m1_w),
        .sta_hold_m1  (sta_hold_m1_w),
        .sto_setup_m1 (sto_setup_m1_w),
        .state_q      (state_w),
        .accept       (accept_w),
        .tmr_load     (tmr_load_w),
        .tmr_val      (tmr_val_w),
        .scl_oe       (scl_oe),
        .sda_oe       (sda_oe),
        .done         (done)
    );
endmodule

// File: rtl/i2c_cond_chk.sv
module i2c_cond_chk
    import i2c_cond_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             done,
    input seq_state_e       state_w,
    input logic [DIV_W-1:0] divh_lat_w
);
    // R6: completion is a single-clock pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: completion leaves both lines equal (both low after start, both released after stop)
    p_done_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (scl_oe == sda_oe));

    // R2: SDA falls with SCL high only after SCL was already high
    p_sda_fall_after_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> $past(!scl_oe));

    // R5: SDA rises with SCL high only after SCL was already high
    p_sda_rise_after_scl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> $past(!scl_oe));

    // R7: after the done pulse the sequencer is idle again
    p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_w == S_IDLE));

    // R8: captured divider does not move while busy
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_w != S_IDLE) |=> $stable(divh_lat_w));
endmodule

bind i2c_cond_seq i2c_cond_chk #(.DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .done       (done),
    .state_w    (state_w),
    .divh_lat_w (divh_lat_w)
);

// File: tb/i2c_cond_seq_tb.sv
module i2c_cond_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] div_high = 16'd0;
    logic [3:0]  setup_ctl = 4'd0;
    logic        scl_oe;
    logic        sda_oe;
    logic        done;

    always #5 clk = ~clk;

    i2c_cond_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .div_high  (div_high),
        .setup_ctl (setup_ctl),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .done      (done)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // Reference model: expected {scl_oe, sda_oe, done} per clock
    logic [2:0] q_exp[$];
    string      q_tag[$];
    logic [2:0] exp_v = 3'b000;
    string      exp_tag = "R1";
    bit         m_busy = 1'b0;
    logic [1:0] park = 2'b00;
    bit         any_cmd = 1'b0;
    bit         tag_r8 = 1'b0;

    function automatic string tg(string t);
        return tag_r8 ? "R8" : t;
    endfunction

    task automatic push_n(logic [2:0] v, int n, string t);
        for (int i = 0; i < n; i++) begin
            q_exp.push_back(v);
            q_tag.push_back(tg(t));
        end
    endtask

    task automatic build(int op, int h, int u, int p);
        if (op == 3) begin
            push_n(3'b110, 8*h, "R5 R9");
            push_n(3'b010, 8*h*p + 1, "R5");
            push_n(3'b001, 1, "R6");
            park = 2'b00;
        end else begin
            if (op == 2) push_n(3'b100, 8*h, "R4 R9");
            push_n(3'b000, 8*h*u + 1, "R2 R9");
            push_n(3'b010, 8*h*(u+1) - 1, "R3");
            push_n(3'b111, 1, "R6");
            park = 2'b11;
        end
    endtask

    task automatic pop_one();
        exp_v   = q_exp.pop_front();
        exp_tag = q_tag.pop_front();
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            q_exp.delete();
            q_tag.delete();
            m_busy  = 1'b0;
            park    = 2'b00;
            exp_v   = 3'b000;
            exp_tag = "R1";
        end else if (m_busy) begin
            if (q_exp.size() == 0) begin
                m_busy  = 1'b0;
                exp_v   = {park, 1'b0};
                exp_tag = "R7";
            end else begin
                pop_one();
            end
        end else if (cmd_valid && cmd_op != 2'b00) begin
            build(int'(cmd_op), int'(div_high) + 1, int'(setup_ctl[1:0]) + 1,
                  int'(setup_ctl[3:2]) + 1);
            m_busy = 1'b1;
            pop_one();
        end else begin
            exp_v   = {park, 1'b0};
            exp_tag = any_cmd ? "R7" : "R1";
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            cyc++;
            n_vec++;
            if ({scl_oe, sda_oe, done} !== exp_v) begin
                n_bad++;
                $display("FAIL %s cycle %0d: scl_oe/sda_oe/done actual %b expected %b",
                         exp_tag, cyc, {scl_oe, sda_oe, done}, exp_v);
            end
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
                finished = 1'b1;
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic issue(logic [1:0] op, logic [15:0] dh, logic [3:0] ctl);
        @(negedge clk);
        cmd_op    = op;
        div_high  = dh;
        setup_ctl = ctl;
        cmd_valid = 1'b1;
        any_cmd   = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);          // R1 idle after reset

        // R7: op 00 is ignored
        @(negedge clk);
        any_cmd = 1'b1; cmd_op = 2'b00; cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;

        issue(2'b01, 16'd0, 4'b0000);       // R2 R3 start, h=1 u=1
        issue(2'b10, 16'd1, 4'b0010);       // R4 repeated start, h=2 u=3
        issue(2'b11, 16'd0, 4'b1100);       // R5 stop, h=1 p=4
        issue(2'b11, 16'd2, 4'b0100);       // R5 stop from a released bus, p=2

        // R7: stop held through a start, including the done cycle
        @(negedge clk);
        cmd_op = 2'b01; div_high = 16'd1; setup_ctl = 4'b0001; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 2'b11;
        while (m_busy) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();

        // R8: config and commands change mid-sequence
        tag_r8 = 1'b1;
        @(negedge clk);
        cmd_op = 2'b01; div_high = 16'd2; setup_ctl = 4'b0001; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        div_high = 16'd5; setup_ctl = 4'b1111; cmd_op = 2'b10;
        repeat (10) @(negedge clk);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; div_high = 16'd0;
        wait_idle();
        tag_r8 = 1'b0;

        issue(2'b11, 16'd1, 4'b1011);       // R5 stop with p=3
        issue(2'b01, 16'h31, 4'b0000);      // R2 R3 standard-speed start
        issue(2'b10, 16'h31, 4'b0000);      // R4 standard-speed repeated start
        issue(2'b11, 16'h31, 4'b0000);      // R5 standard-speed stop
        repeat (5) @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule